// File: doc/BRIEF.md
# Ternary Signature Match Array

This block is a small ternary content-addressable memory for signature lookup. Each entry holds a fixed-width pattern in which every position is a 0, a 1 or a wildcard. Each position is stored as two bits: a care bit and a value bit. When a search key is presented, it is compared against every valid entry in parallel in a single cycle.

One cycle later the block returns three results:
- a per-entry hit vector that lists every matching entry, for clients that need all matches;
- a flag that says whether anything matched;
- the index of the winning entry, where lower indices take precedence.

A write port loads one entry at a time, giving its value and care mask, or invalidates one entry. The port can be used in any cycle, including cycles in which searches are running, so the signature set can be changed without pausing lookups.

A typical use is packet payload inspection. A prefix signature followed by wildcard positions catches every word that starts with that prefix. The full vector lets a downstream stage deal with rules that overlap.

The block has no state machine. Its sequential state is the entry storage and one output register stage. Each entry is in one of two conditions, empty or loaded. An entry moves from empty to loaded on a load write. It moves from loaded to empty on an invalidating write or on reset. A load write to a loaded entry replaces its pattern.

Top module: `tcam_prio_array`

## Requirements
- R1: While reset is held, and after it is released, every entry is empty and `res_vld`, `hit`, `hit_idx` and `hit_vec` read zero.
- R2: A position with care bit 1 matches only a key bit equal to its value bit. A position with care bit 0 matches either key bit, whatever its value bit holds.
- R3: A key presented with `srch_en` high in cycle t produces its results after the clock edge that ends cycle t. At that point `res_vld` is 1.
- R4: Bit i of `hit_vec` is 1 exactly when entry i is loaded and all of its care positions equal the key.
- R5: `hit` is 1 when any bit of `hit_vec` is set. `hit_idx` is then the lowest index whose bit is set.
- R6: On a search with no matching entry, `hit` is 0 and `hit_idx` is 0.
- R7: A write in cycle t is not seen by a search presented in cycle t. It is seen by searches presented in cycle t+1 and later.
- R8: A write with `wr_keep` = 0 empties the addressed entry. An empty entry never matches, even if every one of its positions is a wildcard.
- R9: After a cycle with `srch_en` low, `res_vld`, `hit`, `hit_idx` and `hit_vec` all read zero.
- R10: An entry that cares only about its upper byte matches every key with that upper byte and no key with a different upper byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| srch_en | input | 1 | Search request this cycle |
| srch_key | input | KEY_W | Key to compare |
| wr_en | input | 1 | Write one entry this cycle |
| wr_idx | input | IDX_W | Entry index to write |
| wr_keep | input | 1 | 1 = load value and mask, 0 = invalidate |
| wr_val | input | KEY_W | Value bits for the entry |
| wr_care | input | KEY_W | Care bits; 0 marks a wildcard position |
| res_vld | output | 1 | Result registers hold a search result |
| hit | output | 1 | At least one entry matched |
| hit_idx | output | IDX_W | Lowest matching index, 0 on a miss |
| hit_vec | output | ENTRIES | One bit per matching entry |

## Verification
Every search result is due exactly one clock edge after its key is driven. The bench drives inputs on the falling edge and computes the expected vector, flag and index from its own model of the table as it stands before that cycle's write. It then waits for the rising edge, applies the write to its model, and compares all four outputs on the following falling edge. This ordering means a search issued in the same cycle as a write is checked against the old contents. Idle cycles are checked the same way against an all-zero result.

// File: rtl/tcam_pkg.sv
package tcam_pkg;
    typedef enum logic {
        WR_DROP = 1'b0,
        WR_LOAD = 1'b1
    } wr_kind_e;
endpackage

// File: rtl/tcam_row.sv
module tcam_row
    import tcam_pkg::*;
#(
    parameter int KEY_W  = 16,
    parameter int IDX_W  = 3,
    parameter int MY_IDX = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_keep,
    input  logic [KEY_W-1:0] wr_val,
    input  logic [KEY_W-1:0] wr_care,
    input  logic [KEY_W-1:0] key,
    output logic             match
);
    localparam logic [IDX_W-1:0] ME = IDX_W'(MY_IDX);

    logic             loaded_q;
    logic [KEY_W-1:0] val_q;
    logic [KEY_W-1:0] care_q;
    logic             sel;
    wr_kind_e         kind;

    assign sel  = wr_en && (wr_idx == ME);
    assign kind = wr_keep ? WR_LOAD : WR_DROP;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            loaded_q <= 1'b0;
            val_q    <= '0;
            care_q   <= '0;
        end else if (sel) begin
            unique case (kind)
                WR_LOAD: begin
                    loaded_q <= 1'b1;
                    val_q    <= wr_val;
                    care_q   <= wr_care;
                end
                WR_DROP: loaded_q <= 1'b0;
            endcase
        end
    end

    always_comb begin
        match = loaded_q && (((key ^ val_q) & care_q) == '0);
    end

    AST_DROP_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !wr_keep) |=> !match) else $error("drop left entry matching"); // R8
endmodule

// File: rtl/tcam_first_set.sv
module tcam_first_set #(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input  logic [N-1:0]     vec,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/tcam_prio_array.sv
module tcam_prio_array #(
    parameter int ENTRIES = 8,
    parameter int KEY_W   = 16,
    parameter int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               srch_en,
    input  logic [KEY_W-1:0]   srch_key,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic               wr_keep,
    input  logic [KEY_W-1:0]   wr_val,
    input  logic [KEY_W-1:0]   wr_care,
    output logic               res_vld,
    output logic               hit,
    output logic [IDX_W-1:0]   hit_idx,
    output logic [ENTRIES-1:0] hit_vec
);
    localparam logic [ENTRIES-1:0] ONE = ENTRIES'(1);

    logic [ENTRIES-1:0] raw_vec;
    logic               raw_any;
    logic [IDX_W-1:0]   raw_idx;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_row
        tcam_row #(
            .KEY_W (KEY_W),
            .IDX_W (IDX_W),
            .MY_IDX(g)
        ) u_row (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (wr_en),
            .wr_idx (wr_idx),
            .wr_keep(wr_keep),
            .wr_val (wr_val),
            .wr_care(wr_care),
            .key    (srch_key),
            .match  (raw_vec[g])
        );
    end

    tcam_first_set #(
        .N    (ENTRIES),
        .IDX_W(IDX_W)
    ) u_first (
        .vec(raw_vec),
        .any(raw_any),
        .idx(raw_idx)
    );

    always_ff @(posedge clk) begin
        if (!rst_n || !srch_en) begin
            res_vld <= 1'b0;
            hit     <= 1'b0;
            hit_idx <= '0;
            hit_vec <= '0;
        end else begin
            res_vld <= 1'b1;
            hit     <= raw_any;
            hit_idx <= raw_idx;
            hit_vec <= raw_vec;
        end
    end

    AST_HIT_AGREES_VEC: assert property (@(posedge clk) disable iff (!rst_n)
        hit == (hit_vec != '0)) else $error("hit flag disagrees with vector"); // R5
    AST_IDX_POINTS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> hit_vec[hit_idx]) else $error("index not a matching entry"); // R5
    AST_IDX_IS_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> ((hit_vec & ((ONE << hit_idx) - ONE)) == '0)) else $error("lower entry also hit"); // R5
    AST_MISS_IDX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (hit_idx == '0)) else $error("miss with nonzero index"); // R6
    AST_SEARCH_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        srch_en |=> res_vld) else $error("result not valid after search"); // R3
    AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !srch_en |=> (!res_vld && !hit && hit_vec == '0)) else $error("idle result not clear"); // R9
endmodule

// File: tb/tcam_prio_array_tb.sv
module tcam_prio_array_tb;
    localparam int ENTRIES = 8;
    localparam int KEY_W   = 16;
    localparam int IDX_W   = 3;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               srch_en = 1'b0;
    logic [KEY_W-1:0]   srch_key = '0;
    logic               wr_en = 1'b0;
    logic [IDX_W-1:0]   wr_idx = '0;
    logic               wr_keep = 1'b0;
    logic [KEY_W-1:0]   wr_val = '0;
    logic [KEY_W-1:0]   wr_care = '0;
    logic               res_vld;
    logic               hit;
    logic [IDX_W-1:0]   hit_idx;
    logic [ENTRIES-1:0] hit_vec;

    int unsigned n_chk = 0;
    int unsigned n_bad = 0;
    int unsigned cyc_cnt = 0;
    bit          done = 1'b0;

    logic             m_vld  [ENTRIES];
    logic [KEY_W-1:0] m_val  [ENTRIES];
    logic [KEY_W-1:0] m_care [ENTRIES];

    always #4 clk = ~clk;

    tcam_prio_array #(.ENTRIES(ENTRIES), .KEY_W(KEY_W), .IDX_W(IDX_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .srch_en(srch_en), .srch_key(srch_key),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_keep(wr_keep), .wr_val(wr_val),
        .wr_care(wr_care), .res_vld(res_vld), .hit(hit), .hit_idx(hit_idx),
        .hit_vec(hit_vec)
    );

    function automatic logic [ENTRIES-1:0] exp_vec(input logic [KEY_W-1:0] k);
        logic [ENTRIES-1:0] v = '0;
        for (int i = 0; i < ENTRIES; i++)
            v[i] = m_vld[i] && (((k ^ m_val[i]) & m_care[i]) == '0);
        return v;
    endfunction

    function automatic logic [IDX_W-1:0] exp_idx(input logic [ENTRIES-1:0] v);
        for (int i = 0; i < ENTRIES; i++)
            if (v[i]) return IDX_W'(i);
        return '0;
    endfunction

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // one cycle: drive at falling edge, result compared at next falling edge
    task automatic cyc(input string tag, input logic en, input logic [KEY_W-1:0] k,
                       input logic we, input int wi, input logic keep,
                       input logic [KEY_W-1:0] v, input logic [KEY_W-1:0] c);
        logic [ENTRIES-1:0] ev;
        srch_en = en; srch_key = k;
        wr_en = we; wr_idx = IDX_W'(wi); wr_keep = keep; wr_val = v; wr_care = c;
        ev = en ? exp_vec(k) : '0;
        @(posedge clk);
        if (we) begin
            m_vld[wi] = keep;
            if (keep) begin m_val[wi] = v; m_care[wi] = c; end
        end
        @(negedge clk);
        chk(tag, "res_vld", 32'(res_vld), 32'(en));
        chk(tag, "hit_vec", 32'(hit_vec), 32'(ev));
        chk(tag, "hit", 32'(hit), 32'(ev != '0));
        chk(tag, "hit_idx", 32'(hit_idx), 32'(exp_idx(ev)));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc_cnt++;
            if (cyc_cnt > 100000) begin
                n_chk++; n_bad++;
                $display("FAIL watchdog actual %0d expected below 100000", cyc_cnt);
                finish_run();
            end
        end
    end

    initial begin
        logic [31:0] seed;
        seed = $urandom(32'd1234);
        for (int i = 0; i < ENTRIES; i++) begin
            m_vld[i] = 1'b0; m_val[i] = '0; m_care[i] = '0;
        end
        repeat (3) @(negedge clk);
        // R1: outputs clear during reset
        chk("R1", "res_vld", 32'(res_vld), 0);
        chk("R1", "hit_vec", 32'(hit_vec), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "hit", 32'(hit), 0);
        chk("R1", "hit_idx", 32'(hit_idx), 0);
        // R1 R6: empty table, search misses
        cyc("R6", 1, 16'hFFFF, 0, 0, 0, 0, 0);
        cyc("R6", 1, 16'h0000, 0, 0, 0, 0, 0);
        // R7: write entry 5 and search the same key in the same cycle -> old contents (miss)
        cyc("R7", 1, 16'hABCD, 1, 5, 1, 16'hABCD, 16'hFFFF);
        chk("R7", "same-cycle write unseen", 32'(hit), 0);
        cyc("R7", 1, 16'hABCD, 0, 0, 0, 0, 0);
        chk("R7", "write seen next cycle", 32'(hit_idx), 5);
        // R10: upper-byte prefix in entry 2
        cyc("R10", 1, 16'hABCD, 1, 2, 1, 16'hAB00, 16'hFF00);
        cyc("R10", 1, 16'hABCD, 0, 0, 0, 0, 0);
        chk("R5", "lowest of two", 32'(hit_idx), 2);
        chk("R4", "both bits", 32'(hit_vec), 32'h24);
        cyc("R10", 1, 16'hAB12, 0, 0, 0, 0, 0);
        cyc("R10", 1, 16'hAC00, 0, 0, 0, 0, 0);
        chk("R10", "other prefix misses", 32'(hit), 0);
        // R2: entry 7 cares about bit0 only with value 1; junk in don't-care value bits
        cyc("R2", 1, 16'h0001, 1, 7, 1, 16'h5A5B, 16'h0001);
        cyc("R2", 1, 16'h0001, 0, 0, 0, 0, 0);
        cyc("R2", 1, 16'hF0F1, 0, 0, 0, 0, 0);
        cyc("R2", 1, 16'h0000, 0, 0, 0, 0, 0);
        // R8: all-wildcard entry 0 matches everything, then invalidate it
        cyc("R8", 1, 16'h1234, 1, 0, 1, 16'h0000, 16'h0000);
        cyc("R8", 1, 16'h1234, 0, 0, 0, 0, 0);
        chk("R5", "wildcard wins", 32'(hit_idx), 0);
        cyc("R8", 1, 16'h1234, 1, 0, 0, 16'hFFFF, 16'h0000);
        cyc("R8", 1, 16'h1234, 0, 0, 0, 0, 0);
        chk("R8", "invalidated never hits", 32'(hit), 0);
        cyc("R8", 1, 16'hABCD, 0, 0, 0, 0, 0);
        // R9: idle cycle
        cyc("R9", 0, 16'hABCD, 0, 0, 0, 0, 0);
        cyc("R3", 1, 16'hABCD, 0, 0, 0, 0, 0);
        // R4 R5 R7: random mix
        for (int n = 0; n < 3000; n++) begin
            logic [KEY_W-1:0] k, v, c;
            int wi, pick;
            logic we, keep, en;
            wi   = int'($urandom_range(ENTRIES - 1));
            we   = ($urandom_range(9) < 3);
            keep = ($urandom_range(9) < 8);
            v    = KEY_W'($urandom);
            c    = KEY_W'($urandom) | KEY_W'($urandom);
            en   = ($urandom_range(9) < 9);
            pick = int'($urandom_range(ENTRIES - 1));
            k    = m_val[pick] ^ (KEY_W'($urandom) & ~m_care[pick]);
            if ($urandom_range(7) == 0) k = k ^ KEY_W'(1 << $urandom_range(KEY_W - 1));
            cyc("R4", en, k, we, wi, keep, v, c);
        end
        cyc("R9", 0, 16'h0, 0, 0, 0, 0, 0);
        finish_run();
    end
endmodule